// File: doc/BRIEF.md
# UART Receive/Transmit Flow Gate

This block sits between a UART's serial shifters and the host-side buffers. Every received 9-bit character passes through it, and the block decides whether the character reaches the host. It also produces the permit that lets the transmitter start its next character. A latched 3-bit mode selects the policy: pass-through, hardware handshake (CTS in, RTS out), software handshake (XON/XOFF characters in both directions), or one of two multidrop address-filter modes. The first multidrop mode gates only reception. The second gates reception and transmission.

Separate receive and transmit enables gate the two paths. An optional half-duplex setting drops characters that arrive while the local transmitter is busy. The host reports its receive-buffer fill level. The block compares this level against high and low watermarks. In hardware mode it drives RTS from the result. In software mode it raises one-cycle requests to send XOFF or XON. The mode and the half-duplex setting are taken only while both enables are low.

Top module: `uart_fc_gate`

## Requirements
- R1: After reset, rx_accept, tx_permit, rts_n, send_xon and send_xoff are all 0.
- R2: While cfg_rx_en is 0, no character is accepted. While cfg_tx_en is 0, tx_permit is 0 on the following cycle.
- R3: In mode 000, and in the reserved modes 101, 110 and 111, which act as 000: every received character, including one with bit 8 set or one equal to the XOFF value, is accepted. It appears on rx_data with rx_accept high in the cycle after rx_valid. tx_permit is 1.
- R4: When the latched half-duplex bit is 1, a character that arrives while tx_busy is 1 is dropped. When the bit is 0, it is accepted.
- R5: In mode 001, tx_permit in the next cycle equals the inverse of the active-low cts_n.
- R6: In mode 001, rts_n rises in the cycle after rx_fill reaches HI_THR (default 48). It stays high while rx_fill is at or above LO_THR (default 16). It falls in the cycle after rx_fill drops below LO_THR. In every other mode rts_n is 0.
- R7: In mode 010, a received character equal to {0, cfg_xoff_char} forces tx_permit to 0. A received character equal to {0, cfg_ctl_char} sets tx_permit back to 1. Neither character is accepted. Other characters are accepted while stopped. The stop state clears while cfg_tx_en is 0.
- R8: In mode 010, send_xoff pulses for exactly one cycle when rx_fill reaches HI_THR. send_xon pulses for exactly one cycle when rx_fill then falls below LO_THR. The two are never high together.
- R9: In modes 011 and 100, a character with bit 8 set is an address character and is never accepted. The match flag is set if bits 7:0 equal cfg_ctl_char and cleared otherwise.
- R10: In mode 011, data characters (bit 8 clear) are accepted only while matched. tx_permit stays 1 whatever the match state.
- R11: In mode 100, tx_permit is 1 only while the match flag is set.
- R12: The match flag clears while cfg_rx_en is 0, so after re-enabling, data is dropped until a new address match.
- R13: cfg_mode and cfg_half_duplex are latched only in cycles where both enables are 0. Changes made while either enable is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_en | input | 1 | Receive path enable |
| cfg_tx_en | input | 1 | Transmit path enable |
| cfg_mode | input | 3 | Policy select (000 none, 001 HW, 010 SW, 011 multidrop RX, 100 multidrop RX/TX) |
| cfg_half_duplex | input | 1 | Drop reception while transmitting |
| cfg_ctl_char | input | 8 | XON character, or unicast address in multidrop modes |
| cfg_xoff_char | input | 8 | XOFF character |
| rx_char | input | 9 | Received character, bit 8 marks an address |
| rx_valid | input | 1 | rx_char valid strobe |
| tx_busy | input | 1 | Transmitter is shifting |
| cts_n | input | 1 | Clear-to-send, active low |
| rx_fill | input | 8 | Host receive buffer fill level |
| rx_accept | output | 1 | Character forwarded this cycle |
| rx_data | output | 9 | Forwarded character |
| tx_permit | output | 1 | Transmitter may start a character |
| rts_n | output | 1 | Request-to-send, active low |
| send_xon | output | 1 | One-cycle request to transmit XON |
| send_xoff | output | 1 | One-cycle request to transmit XOFF |

## Verification
The bench sends address characters that match and then miss. A design that kept a stale match, or forwarded address bytes, would pass data that should be filtered or would open transmit in mode 100. It sends the XOFF value in pass-through and reserved modes, and changes the mode while the block is enabled. A decoder that does not fold reserved codes, or a latch that follows live writes, would swallow that character. It also walks rx_fill across the gap between the watermarks. This catches hysteresis that toggles RTS at the wrong level or repeats XOFF requests. Finally it drops receive enable in the middle of a session, which exposes a match flag that survives the disable.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic [2:0] {
        FC_NONE    = 3'b000,
        FC_HW      = 3'b001,
        FC_SW      = 3'b010,
        FC_MD_RX   = 3'b011,
        FC_MD_RXTX = 3'b100
    } fc_mode_e;

    // Reserved codes fold onto the pass-through policy.
    function automatic fc_mode_e fc_decode(input logic [2:0] raw);
        fc_mode_e m;
        case (raw)
            3'b001:  m = FC_HW;
            3'b010:  m = FC_SW;
            3'b011:  m = FC_MD_RX;
            3'b100:  m = FC_MD_RXTX;
            default: m = FC_NONE;
        endcase
        return m;
    endfunction

    function automatic logic fc_is_md(input fc_mode_e m);
        return (m == FC_MD_RX) || (m == FC_MD_RXTX);
    endfunction

endpackage

// File: rtl/uart_fc_cfg.sv
module uart_fc_cfg
    import uart_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic [2:0] mode_raw,
    input  logic       half_duplex,
    output fc_mode_e   mode_o,
    output logic       hd_o
);

    typedef struct packed {
        fc_mode_e mode;
        logic     hd;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rx_en && !tx_en) begin
            cfg_d.mode = fc_decode(mode_raw);
            cfg_d.hd   = half_duplex;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: FC_NONE, hd: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o = cfg_q.mode;
    assign hd_o   = cfg_q.hd;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en || tx_en) |=> ($stable(mode_o) && $stable(hd_o))); // R13

endmodule

// File: rtl/uart_fc_rxfilt.sv
module uart_fc_rxfilt
    import uart_fc_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tx_en,
    input  fc_mode_e          mode,
    input  logic              hd,
    input  logic              tx_busy,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_valid,
    input  logic [CHAR_W-2:0] ctl_char,
    input  logic [CHAR_W-2:0] xoff_char,
    output logic              accept_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              match_o,
    output logic              match_nx,
    output logic              stop_nx
);

    localparam int ADDR_BIT = CHAR_W - 1;

    typedef struct packed {
        logic              accept;
        logic [CHAR_W-1:0] data;
        logic              match;
        logic              stop;
    } rx_s;

    rx_s rx_d, rx_q;

    logic is_md, is_sw, blanked, is_addr, is_xoff, is_xon;

    always_comb begin
        is_md   = fc_is_md(mode);
        is_sw   = (mode == FC_SW);
        blanked = hd && tx_busy;
        is_addr = rx_char[ADDR_BIT];
        is_xoff = (rx_char == {1'b0, xoff_char});
        is_xon  = (rx_char == {1'b0, ctl_char});

        rx_d        = rx_q;
        rx_d.accept = 1'b0;

        if (!rx_en) begin
            rx_d.match = 1'b0;
        end else if (rx_valid && !blanked) begin
            if (is_md && is_addr) begin
                rx_d.match = (rx_char[ADDR_BIT-1:0] == ctl_char);
            end else if (is_sw && is_xoff) begin
                rx_d.stop = 1'b1;
            end else if (is_sw && is_xon) begin
                rx_d.stop = 1'b0;
            end else if (!is_md || rx_q.match) begin
                rx_d.accept = 1'b1;
                rx_d.data   = rx_char;
            end
        end

        if (!tx_en || !is_sw) begin
            rx_d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign accept_o = rx_q.accept;
    assign data_o   = rx_q.data;
    assign match_o  = rx_q.match;
    assign match_nx = rx_d.match;
    assign stop_nx  = rx_d.stop;

    AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !accept_o); // R2
    AST_HD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && hd && tx_busy) |=> !accept_o); // R4
    AST_ADDR_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_is_md(mode) && rx_char[ADDR_BIT]) |=> !accept_o); // R9
    AST_MD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_is_md(mode) && !match_o) |=> !accept_o); // R10
    AST_SW_NOFWD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode == FC_SW && rx_char == {1'b0, xoff_char}) |=> !accept_o); // R7
    AST_MATCH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !match_o); // R12

endmodule

// File: rtl/uart_fc_txgate.sv
module uart_fc_txgate
    import uart_fc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tx_en,
    input  fc_mode_e mode,
    input  logic     cts_n,
    input  logic     match_nx,
    input  logic     stop_nx,
    input  logic     match_q,
    output logic     permit_o
);

    typedef struct packed {
        logic permit;
    } tx_s;

    tx_s tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (!tx_en) begin
            tx_d.permit = 1'b0;
        end else begin
            case (mode)
                FC_HW:      tx_d.permit = !cts_n;
                FC_SW:      tx_d.permit = !stop_nx;
                FC_MD_RXTX: tx_d.permit = match_nx;
                default:    tx_d.permit = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign permit_o = tx_q.permit;

    AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !permit_o); // R2
    AST_CTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FC_HW && cts_n) |=> !permit_o); // R5
    AST_MD_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (permit_o && mode == FC_MD_RXTX) |-> match_q); // R11

endmodule

// File: rtl/uart_fc_watermark.sv
module uart_fc_watermark
    import uart_fc_pkg::*;
#(
    parameter int FILL_W = 8,
    parameter int HI_THR = 48,
    parameter int LO_THR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  fc_mode_e          mode,
    input  logic [FILL_W-1:0] fill,
    output logic              rts_n_o,
    output logic              xon_o,
    output logic              xoff_o
);

    localparam logic [FILL_W-1:0] HI_V = FILL_W'(HI_THR);
    localparam logic [FILL_W-1:0] LO_V = FILL_W'(LO_THR);

    typedef struct packed {
        logic above;
        logic rts_n;
        logic xon;
        logic xoff;
    } wm_s;

    wm_s wm_d, wm_q;
    logic active, is_sw;

    always_comb begin
        is_sw  = (mode == FC_SW);
        active = rx_en && ((mode == FC_HW) || is_sw);
        wm_d   = wm_q;

        if (!active) begin
            wm_d.above = 1'b0;
        end else if (!wm_q.above && fill >= HI_V) begin
            wm_d.above = 1'b1;
        end else if (wm_q.above && fill < LO_V) begin
            wm_d.above = 1'b0;
        end

        wm_d.rts_n = (mode == FC_HW) && wm_d.above;
        wm_d.xoff  = is_sw && active && !wm_q.above && wm_d.above;
        wm_d.xon   = is_sw && active && wm_q.above && !wm_d.above;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wm_q <= '0;
        end else begin
            wm_q <= wm_d;
        end
    end

    assign rts_n_o = wm_q.rts_n;
    assign xon_o   = wm_q.xon;
    assign xoff_o  = wm_q.xoff;

    initial begin
        AST_THR_ORDER: assert (HI_THR > LO_THR); // R6
    end

    AST_RTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && mode == FC_HW && fill >= HI_V) |=> rts_n_o); // R6
    AST_RTS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != FC_HW) |=> !rts_n_o); // R6
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(xon_o && xoff_o)); // R8
    AST_XOFF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_o |=> !xoff_o); // R8

endmodule

// File: rtl/uart_fc_gate.sv
module uart_fc_gate
    import uart_fc_pkg::*;
#(
    parameter int CHAR_W = 9,
    parameter int FILL_W = 8,
    parameter int HI_THR = 48,
    parameter int LO_THR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rx_en,
    input  logic              cfg_tx_en,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_half_duplex,
    input  logic [CHAR_W-2:0] cfg_ctl_char,
    input  logic [CHAR_W-2:0] cfg_xoff_char,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_valid,
    input  logic              tx_busy,
    input  logic              cts_n,
    input  logic [FILL_W-1:0] rx_fill,
    output logic              rx_accept,
    output logic [CHAR_W-1:0] rx_data,
    output logic              tx_permit,
    output logic              rts_n,
    output logic              send_xon,
    output logic              send_xoff
);

    fc_mode_e mode_w;
    logic     hd_w;
    logic     match_w, match_nx_w, stop_nx_w;

    uart_fc_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (cfg_rx_en),
        .tx_en       (cfg_tx_en),
        .mode_raw    (cfg_mode),
        .half_duplex (cfg_half_duplex),
        .mode_o      (mode_w),
        .hd_o        (hd_w)
    );

    uart_fc_rxfilt #(.CHAR_W(CHAR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (cfg_rx_en),
        .tx_en     (cfg_tx_en),
        .mode      (mode_w),
        .hd        (hd_w),
        .tx_busy   (tx_busy),
        .rx_char   (rx_char),
        .rx_valid  (rx_valid),
        .ctl_char  (cfg_ctl_char),
        .xoff_char (cfg_xoff_char),
        .accept_o  (rx_accept),
        .data_o    (rx_data),
        .match_o   (match_w),
        .match_nx  (match_nx_w),
        .stop_nx   (stop_nx_w)
    );

    uart_fc_txgate u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (cfg_tx_en),
        .mode     (mode_w),
        .cts_n    (cts_n),
        .match_nx (match_nx_w),
        .stop_nx  (stop_nx_w),
        .match_q  (match_w),
        .permit_o (tx_permit)
    );

    uart_fc_watermark #(
        .FILL_W (FILL_W),
        .HI_THR (HI_THR),
        .LO_THR (LO_THR)
    ) u_wm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (cfg_rx_en),
        .mode    (mode_w),
        .fill    (rx_fill),
        .rts_n_o (rts_n),
        .xon_o   (send_xon),
        .xoff_o  (send_xoff)
    );

    AST_MD_RX_TX_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_en && mode_w == FC_MD_RX) |=> tx_permit); // R10

endmodule

// File: tb/uart_fc_gate_tb_top.sv
module uart_fc_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HI = 48;
    localparam int LO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rx_en = 1'b0;
    logic       cfg_tx_en = 1'b0;
    logic [2:0] cfg_mode = 3'b000;
    logic       cfg_half_duplex = 1'b0;
    logic [7:0] cfg_ctl_char = 8'h11;
    logic [7:0] cfg_xoff_char = 8'h13;
    logic [8:0] rx_char = '0;
    logic       rx_valid = 1'b0;
    logic       tx_busy = 1'b0;
    logic       cts_n = 1'b0;
    logic [7:0] rx_fill = '0;
    logic       rx_accept;
    logic [8:0] rx_data;
    logic       tx_permit, rts_n, send_xon, send_xoff;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fc_gate dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_rx_en (cfg_rx_en), .cfg_tx_en (cfg_tx_en),
        .cfg_mode (cfg_mode), .cfg_half_duplex (cfg_half_duplex),
        .cfg_ctl_char (cfg_ctl_char), .cfg_xoff_char (cfg_xoff_char),
        .rx_char (rx_char), .rx_valid (rx_valid), .tx_busy (tx_busy),
        .cts_n (cts_n), .rx_fill (rx_fill),
        .rx_accept (rx_accept), .rx_data (rx_data), .tx_permit (tx_permit),
        .rts_n (rts_n), .send_xon (send_xon), .send_xoff (send_xoff)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Latch configuration with both paths off, then enable.
    task automatic setup(input logic [2:0] m, input logic hd, input logic rxe, input logic txe);
        cfg_rx_en = 1'b0; cfg_tx_en = 1'b0;
        cfg_mode = m; cfg_half_duplex = hd;
        tick();
        cfg_rx_en = rxe; cfg_tx_en = txe;
        tick();
    endtask

    // Drive one character; return the accept/data seen the cycle after.
    task automatic send(input logic [8:0] c, output logic acc, output logic [8:0] dat);
        rx_char = c; rx_valid = 1'b1;
        tick();
        rx_valid = 1'b0;
        acc = rx_accept; dat = rx_data;
    endtask

    task automatic t_reset();
        chk("R1 rx_accept", 16'(rx_accept), 16'h0);
        chk("R1 tx_permit", 16'(tx_permit), 16'h0);
        chk("R1 rts_n", 16'(rts_n), 16'h0);
        chk("R1 send_xon", 16'(send_xon), 16'h0);
        chk("R1 send_xoff", 16'(send_xoff), 16'h0);
    endtask

    task automatic t_none();
        logic a; logic [8:0] d;
        setup(3'b000, 1'b0, 1'b1, 1'b1);
        chk("R3 permit", 16'(tx_permit), 16'h1);
        send(9'h055, a, d);
        chk("R3 accept", 16'(a), 16'h1);
        chk("R3 data", 16'(d), 16'h055);
        send(9'h1AA, a, d);
        chk("R3 bit8 data", 16'({a, d}), 16'h3AA);
        setup(3'b110, 1'b0, 1'b1, 1'b1);
        send(9'h013, a, d);
        chk("R3 reserved xoff value passes", 16'({a, d}), 16'h213);
        chk("R3 reserved permit", 16'(tx_permit), 16'h1);
    endtask

    task automatic t_enable();
        logic a; logic [8:0] d;
        setup(3'b000, 1'b0, 1'b0, 1'b0);
        send(9'h033, a, d);
        chk("R2 rx disabled drop", 16'(a), 16'h0);
        chk("R2 tx disabled permit", 16'(tx_permit), 16'h0);
    endtask

    task automatic t_halfdup();
        logic a; logic [8:0] d;
        setup(3'b000, 1'b1, 1'b1, 1'b1);
        tx_busy = 1'b1;
        send(9'h021, a, d);
        chk("R4 blanked while busy", 16'(a), 16'h0);
        tx_busy = 1'b0;
        send(9'h022, a, d);
        chk("R4 idle accepted", 16'(a), 16'h1);
        setup(3'b000, 1'b0, 1'b1, 1'b1);
        tx_busy = 1'b1;
        send(9'h023, a, d);
        chk("R4 full duplex accepted", 16'(a), 16'h1);
        tx_busy = 1'b0;
    endtask

    task automatic t_hw();
        setup(3'b001, 1'b0, 1'b1, 1'b1);
        chk("R5 permit cts low", 16'(tx_permit), 16'h1);
        cts_n = 1'b1; tick();
        chk("R5 permit cts high", 16'(tx_permit), 16'h0);
        cts_n = 1'b0; tick();
        chk("R5 permit restored", 16'(tx_permit), 16'h1);
        rx_fill = 8'(HI - 1); tick();
        chk("R6 below high", 16'(rts_n), 16'h0);
        rx_fill = 8'(HI); tick();
        chk("R6 at high", 16'(rts_n), 16'h1);
        rx_fill = 8'(LO); tick();
        chk("R6 in gap holds", 16'(rts_n), 16'h1);
        rx_fill = 8'(LO - 1); tick();
        chk("R6 below low", 16'(rts_n), 16'h0);
        rx_fill = 8'(30); tick();
        chk("R6 gap from below", 16'(rts_n), 16'h0);
        rx_fill = '0;
    endtask

    task automatic t_sw();
        logic a; logic [8:0] d;
        setup(3'b010, 1'b0, 1'b1, 1'b1);
        send(9'h013, a, d);
        chk("R7 xoff not forwarded", 16'(a), 16'h0);
        chk("R7 xoff blocks", 16'(tx_permit), 16'h0);
        send(9'h041, a, d);
        chk("R7 data while stopped", 16'({a, d}), 16'h241);
        send(9'h011, a, d);
        chk("R7 xon not forwarded", 16'(a), 16'h0);
        chk("R7 xon unblocks", 16'(tx_permit), 16'h1);
        rx_fill = 8'(HI); tick();
        chk("R8 xoff request", 16'({send_xoff, send_xon}), 16'h2);
        tick();
        chk("R8 xoff one cycle", 16'({send_xoff, send_xon}), 16'h0);
        rx_fill = 8'(LO); tick();
        chk("R8 no xon in gap", 16'(send_xon), 16'h0);
        rx_fill = 8'(LO - 1); tick();
        chk("R8 xon request", 16'({send_xoff, send_xon}), 16'h1);
        tick();
        chk("R8 xon one cycle", 16'(send_xon), 16'h0);
        chk("R6 rts idle in sw", 16'(rts_n), 16'h0);
        rx_fill = '0;
    endtask

    task automatic t_md_rx();
        logic a; logic [8:0] d;
        cfg_ctl_char = 8'h42;
        setup(3'b011, 1'b0, 1'b1, 1'b1);
        send(9'h055, a, d);
        chk("R10 drop before match", 16'(a), 16'h0);
        chk("R10 tx free", 16'(tx_permit), 16'h1);
        send(9'h142, a, d);
        chk("R9 address not forwarded", 16'(a), 16'h0);
        send(9'h056, a, d);
        chk("R10 accept after match", 16'({a, d}), 16'h256);
        send(9'h143, a, d);
        chk("R9 miss not forwarded", 16'(a), 16'h0);
        send(9'h057, a, d);
        chk("R9 miss clears match", 16'(a), 16'h0);
    endtask

    task automatic t_md_rxtx();
        logic a; logic [8:0] d;
        setup(3'b100, 1'b0, 1'b1, 1'b1);
        chk("R11 blocked before match", 16'(tx_permit), 16'h0);
        send(9'h142, a, d);
        chk("R11 open after match", 16'(tx_permit), 16'h1);
        send(9'h060, a, d);
        chk("R11 data after match", 16'(a), 16'h1);
        cfg_rx_en = 1'b0; tick();
        cfg_rx_en = 1'b1; tick();
        send(9'h061, a, d);
        chk("R12 match lost on disable", 16'(a), 16'h0);
        chk("R12 tx closed", 16'(tx_permit), 16'h0);
        send(9'h142, a, d);
        send(9'h1FF, a, d);
        chk("R11 closed on miss", 16'(tx_permit), 16'h0);
    endtask

    task automatic t_mode_hold();
        logic a; logic [8:0] d;
        setup(3'b000, 1'b0, 1'b1, 1'b1);
        cfg_mode = 3'b010; cfg_half_duplex = 1'b1;
        tick();
        tx_busy = 1'b1;
        send(9'h013, a, d);
        chk("R13 live write ignored", 16'({a, d}), 16'h213);
        chk("R13 permit kept", 16'(tx_permit), 16'h1);
        tx_busy = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_none();
        t_enable();
        t_halfdup();
        t_hw();
        t_sw();
        t_md_rx();
        t_md_rxtx();
        t_mode_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule